// File: doc/BRIEF.md
# Carry-Save Multi-Operand Accumulator

This block adds up a stream of unsigned operands and hands back their total as an ordinary binary number. Between operands the running total is kept in redundant form: every bit position holds a digit from 0 to 2, split over two registered vectors, a sum vector and a carry vector. A new operand is folded in by a row of independent 3:2 compressors, one per bit. Each compressor's carry output is wired one position higher. No carry ever travels along the word while operands are arriving, so the per-operand step costs one full-adder delay whatever the width.

When the caller raises the finish request, a single carry-propagate adder resolves sum plus carry into binary. That adder uses lookahead groups chained by ripple. The binary value is registered and flagged by a one-cycle valid pulse. The same edge empties the total so that the next sequence can start at once. A clear input empties the total without producing a result. The internal width is the operand width plus enough headroom bits for the largest supported operand count, so no sum of up to that many operands is lost.

Top module: `csa_accum`

## Requirements
- R1: After reset the result valid output is 0, and a finish request issued with no operands returns a result of 0.
- R2: After any sequence of 1 to MAX_OPS accepted operands (op_vld_i high at a clock edge), a finish request returns their exact unsigned sum.
- R3: The result valid output is high for exactly the one cycle after the edge at which fin_i was sampled high. The result data keeps its value until the next finish.
- R4: A finish empties the running total. An operand accepted at the same edge as a finish is not part of that result; it becomes the first term of the next sequence.
- R5: clr_i empties the running total at the next edge and takes priority over an operand presented at the same edge, which is discarded.
- R6: Cycles with op_vld_i low, clr_i low and fin_i low leave the running total unchanged, whatever value op_dat_i carries.
- R7: The sum of MAX_OPS operands that are all ones (MAX_OPS*(2^OP_W-1)) is returned exactly in the ACC_W = OP_W + clog2(MAX_OPS) bit result.
- R8: When clr_i and fin_i are high at the same edge, the result reports the total held before that edge, and the total is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty the running total |
| op_vld_i | input | 1 | Operand present this cycle |
| op_dat_i | input | OP_W | Unsigned operand |
| fin_i | input | 1 | Resolve the total and restart |
| res_vld_o | output | 1 | One-cycle pulse: result data is new |
| res_dat_o | output | ACC_W | Binary total of the finished sequence |

## Verification
The bench uses the defaults: OP_W = 8, MAX_OPS = 16 and a lookahead group of 4 bits. This gives a 12-bit total resolved by three lookahead groups, so a full-width resolve with all-ones operands sends a carry across both group boundaries. Sixteen operands of 255 reach 4080, which sits just below the 12-bit limit and exercises the headroom bits. Random sequences of 1 to 16 operands with idle gaps leave the saved-carry vector densely populated before the resolve. Directed cases cover the same-edge conflicts between clear, operand and finish.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Majority of three bits: the carry leg of a full adder.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Parity of three bits: the sum leg of a full adder.
    function automatic logic par3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

endpackage

// File: rtl/csa_compress_row.sv
// One row of 3:2 compressors. Every position is independent; the carry
// vector leaves already shifted up by one position, with bit 0 tied low.
module csa_compress_row
    import csa_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] cry_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);

    assign cry_o[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = par3(sum_i[i], cry_i[i], add_i[i]);
        if (i < W - 1) begin : g_cry
            assign cry_o[i+1] = maj3(sum_i[i], cry_i[i], add_i[i]);
        end
    end

endmodule

// File: rtl/csa_lookahead_add.sv
// Carry-propagate adder: lookahead inside each group, ripple between groups.
module csa_lookahead_add
    import csa_pkg::*;
#(
    parameter int W   = 12,
    parameter int GRP = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_o
);

    localparam int NGRP = ceil_div(W, GRP);

    logic [NGRP-1:0] gcin;
    assign gcin[0] = 1'b0;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        localparam int LO = gi * GRP;
        localparam int GW = ((W - LO) < GRP) ? (W - LO) : GRP;

        logic [GW-1:0] gen, prp;
        logic [GW:0]   cv;

        assign gen = a_i[LO +: GW] & b_i[LO +: GW];
        assign prp = a_i[LO +: GW] | b_i[LO +: GW];

        // Each in-group carry is a flat sum of products of gen/prp and cin.
        always_comb begin
            logic term;
            cv    = '0;
            cv[0] = gcin[gi];
            for (int j = 1; j <= GW; j++) begin
                term = gcin[gi];
                for (int m = 0; m < j; m++) term = term & prp[m];
                cv[j] = term;
                for (int k = 0; k < j; k++) begin
                    term = gen[k];
                    for (int m = k + 1; m < j; m++) term = term & prp[m];
                    cv[j] = cv[j] | term;
                end
            end
        end

        assign s_o[LO +: GW] = a_i[LO +: GW] ^ b_i[LO +: GW] ^ cv[GW-1:0];

        if (gi < NGRP - 1) begin : g_chain
            assign gcin[gi+1] = cv[GW];
        end
    end

endmodule

// File: rtl/csa_accum.sv
module csa_accum
    import csa_pkg::*;
#(
    parameter int OP_W    = 8,
    parameter int MAX_OPS = 16,
    parameter int GRP     = 4,
    localparam int ACC_W  = OP_W + $clog2(MAX_OPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             op_vld_i,
    input  logic [OP_W-1:0]  op_dat_i,
    input  logic             fin_i,
    output logic             res_vld_o,
    output logic [ACC_W-1:0] res_dat_o
);

    typedef struct packed {
        logic [ACC_W-1:0] sum;
        logic [ACC_W-1:0] cry;
        logic [ACC_W-1:0] res;
        logic             res_vld;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [ACC_W-1:0] op_ext;
    logic [ACC_W-1:0] row_sum, row_cry;
    logic [ACC_W-1:0] resolved;

    assign op_ext = ACC_W'(op_dat_i);

    csa_compress_row #(.W(ACC_W)) u_row (
        .sum_i (st_q.sum),
        .cry_i (st_q.cry),
        .add_i (op_ext),
        .sum_o (row_sum),
        .cry_o (row_cry)
    );

    csa_lookahead_add #(.W(ACC_W), .GRP(GRP)) u_resolve (
        .a_i (st_q.sum),
        .b_i (st_q.cry),
        .s_o (resolved)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res_vld = fin_i;
        if (fin_i) begin
            st_d.res = resolved;
        end
        if (clr_i) begin
            st_d.sum = '0;
            st_d.cry = '0;
        end else if (op_vld_i) begin
            if (fin_i) begin
                // Operand opens the next sequence on its own.
                st_d.sum = op_ext;
                st_d.cry = '0;
            end else begin
                st_d.sum = row_sum;
                st_d.cry = row_cry;
            end
        end else if (fin_i) begin
            st_d.sum = '0;
            st_d.cry = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o = st_q.res_vld;
    assign res_dat_o = st_q.res;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.sum == '0 && st_q.cry == '0)); // R5

    AST_STEP_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld_i && !clr_i && !fin_i) |=>
        (ACC_W'(st_q.sum + st_q.cry) ==
         ACC_W'($past(st_q.sum) + $past(st_q.cry) + ACC_W'($past(op_dat_i))))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_vld_i && !clr_i && !fin_i) |=> ($stable(st_q.sum) && $stable(st_q.cry))); // R6

    AST_PULSE_FROM_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> !res_vld_o); // R3

    AST_RESULT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> (res_dat_o == ACC_W'($past(st_q.sum) + $past(st_q.cry)))); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(res_dat_o)); // R3

endmodule

// File: tb/csa_accum_test.sv
module csa_accum_test;

    localparam int CLK_PERIOD = 10;
    localparam int OP_W    = 8;
    localparam int MAX_OPS = 16;
    localparam int ACC_W   = OP_W + $clog2(MAX_OPS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_i = 1'b0;
    logic             op_vld_i = 1'b0;
    logic [OP_W-1:0]  op_dat_i = '0;
    logic             fin_i = 1'b0;
    logic             res_vld_o;
    logic [ACC_W-1:0] res_dat_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int seed = 0;

    csa_accum #(.OP_W(OP_W), .MAX_OPS(MAX_OPS)) uut (
        .clk, .rst_n, .clr_i, .op_vld_i, .op_dat_i, .fin_i, .res_vld_o, .res_dat_o
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int wrap(input int v);
        return v % (1 << ACC_W);
    endfunction

    function automatic int all_ones_sum(input int n);
        return n * ((1 << OP_W) - 1);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int v);
        op_vld_i = 1'b1;
        op_dat_i = OP_W'(v);
        tick();
        op_vld_i = 1'b0;
        op_dat_i = OP_W'($urandom(seed));
    endtask

    task automatic finish_chk(input string req, input int exp);
        fin_i = 1'b1;
        tick();
        fin_i = 1'b0;
        chk({req, " valid"}, int'(res_vld_o), 1);
        chk({req, " data"}, int'(res_dat_o), wrap(exp));
        tick();
        chk("R3 pulse drop", int'(res_vld_o), 0);
        chk("R3 data held", int'(res_dat_o), wrap(exp));
    endtask

    initial begin
        int n, v, sum;
        seed = 32'h5eed1;
        void'($urandom(seed));
        repeat (3) tick();
        chk("R1 reset valid", int'(res_vld_o), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 reset valid", int'(res_vld_o), 0);
        finish_chk("R1 empty finish", 0);

        send(37);
        finish_chk("R2 single", 37);

        for (int i = 0; i < MAX_OPS; i++) send((1 << OP_W) - 1);
        finish_chk("R7 all ones", all_ones_sum(MAX_OPS));

        // R6: idle cycles with noisy data
        send(100);
        for (int i = 0; i < 5; i++) begin
            op_dat_i = OP_W'($urandom(seed));
            tick();
        end
        send(23);
        finish_chk("R6 idle gap", 123);

        // R4: operand at the same edge as finish
        send(9); send(11);
        fin_i = 1'b1; op_vld_i = 1'b1; op_dat_i = 8'd7;
        tick();
        fin_i = 1'b0; op_vld_i = 1'b0;
        chk("R4 same-edge result", int'(res_dat_o), 20);
        chk("R4 same-edge valid", int'(res_vld_o), 1);
        send(5);
        finish_chk("R4 next sequence", 12);

        // R5: clear beats operand
        send(200); send(40);
        clr_i = 1'b1; op_vld_i = 1'b1; op_dat_i = 8'd99;
        tick();
        clr_i = 1'b0; op_vld_i = 1'b0;
        finish_chk("R5 clear priority", 0);
        send(3);
        clr_i = 1'b1;
        tick();
        clr_i = 1'b0;
        send(4);
        finish_chk("R5 clear then op", 4);

        // R8: clear with finish
        send(50);
        clr_i = 1'b1; fin_i = 1'b1;
        tick();
        clr_i = 1'b0; fin_i = 1'b0;
        chk("R8 clr+fin result", int'(res_dat_o), 50);
        chk("R8 clr+fin valid", int'(res_vld_o), 1);
        tick();
        finish_chk("R8 emptied", 0);

        // R2: random sequences with gaps
        for (int s = 0; s < 40; s++) begin
            n = 1 + int'($urandom(seed) % MAX_OPS);
            sum = 0;
            for (int k = 0; k < n; k++) begin
                v = int'($urandom(seed) % (1 << OP_W));
                if (s % 5 == 0) v = (1 << OP_W) - 1 - (k % 2);
                sum += v;
                send(v);
                if (($urandom(seed) % 4) == 0) tick();
            end
            finish_chk("R2 random", sum);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule